// File: doc/BRIEF.md
# Error NMI to SMI Logic

This block gathers bus parity errors, system errors and channel-check errors into a single non-maskable-interrupt condition. It does not drive that condition onto a pin. Instead it raises a one-cycle SMI request, and firmware then services the event. The block also holds the legacy system-control byte at I/O port 061h. That byte gates the speaker from the Timer2 output, enables each error path, and reads back the timer outputs and the latched error status. The master NMI enable is bit 7 of any write to the RTC index port 070h.

Two PCI configuration bits qualify a parity error: the parity-error enable and the parity-signals-system-error enable. A system error needs only the system-error enable. A qualified parity or system error sets the error status bit, but only while the error-path enable in port 061h is set. An I/O-check strobe sets the check status bit while the check-path enable is set. The NMI condition is high when the master enable is set and either status bit is set. Each rise of that condition produces exactly one SMI pulse. The programmable timers and the interrupt controller sit outside this block.

The I/O interface is a plain strobe interface with no back-pressure. A write takes effect at the clock edge where `io_wr` is high. Read data is combinational and valid in the same cycle as `io_rd`.

Top module: `err_nmi_smi`

## Requirements
- R1: After reset, every enable and status bit is 0, `smi_req` is 0 and `spk_out` is 0.
- R2: `spk_out` equals `tmr2_out` AND port 061h bit 1 (speaker enable). It is 0 while that bit is 0.
- R3: Reading port 061h returns these bits: bit 0 = 0, bit 1 = speaker enable, bit 2 = error-path enable, bit 3 = check-path enable, bit 4 = `tmr1_out`, bit 5 = `tmr2_out`, bit 6 = check status, bit 7 = error status.
- R4: A `perr_pulse` sets the error status only when `cfg_perr_en` and `cfg_perr_to_serr` are both 1.
- R5: A `serr_pulse` sets the error status only when `cfg_serr_en` is 1.
- R6: A status bit latches on its qualified strobe only while its port 061h enable (bit 2 for error, bit 3 for check) is 1. Writing that enable bit as 0 clears the status at the same edge, and the status stays 0 while the enable is 0.
- R7: When the NMI condition (master enable AND (error status OR check status)) rises after a clock edge, `smi_req` is high for exactly the one following cycle.
- R8: While the NMI condition stays high, further strobes do not produce another `smi_req` pulse.
- R9: The master enable is bit 7 of a port 070h write. While it is 0, no SMI is requested. Setting it while a status bit is pending produces one SMI pulse.
- R10: Reading port 070h returns bits 6:0 of the last value written there, with bit 7 always 0.
- R11: `io_rdata` is 0 when `io_rd` is low or the address matches neither port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_wr | input | 1 | I/O write strobe |
| io_rd | input | 1 | I/O read strobe |
| io_addr | input | ADDR_W | I/O address |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, combinational |
| cfg_perr_en | input | 1 | Parity-error enable (PCI command) |
| cfg_serr_en | input | 1 | System-error enable (PCI command) |
| cfg_perr_to_serr | input | 1 | Parity errors signal system error |
| perr_pulse | input | 1 | Parity error strobe |
| serr_pulse | input | 1 | System error strobe |
| iochk_pulse | input | 1 | I/O channel-check strobe |
| tmr1_out | input | 1 | Timer1 output (refresh toggle) |
| tmr2_out | input | 1 | Timer2 output (speaker data) |
| spk_out | output | 1 | Gated speaker output |
| smi_req | output | 1 | One-cycle SMI request |

## Verification
The parity strobe is tested with each configuration enable set alone and then with both set. This shows that the path is an AND of both bits and not an OR. The system strobe is tested with its enable off and on. The check strobe is tested with its port enable off and on. Strobes that arrive while the condition is already high show that the pulse follows the rising edge and not the level. Enabling the master bit after a status is already pending shows that the rise can also come from the master enable. Counting pulses over a window tells a single pulse apart from a stuck or repeating request.

// File: rtl/err_nmi_pkg.sv
package err_nmi_pkg;
  // Port 061h bit positions; firmware decodes these, so they are fixed.
  localparam int unsigned PB_SPK   = 1;
  localparam int unsigned PB_ERREN = 2;
  localparam int unsigned PB_CHKEN = 3;
  localparam int unsigned PB_TMR1  = 4;
  localparam int unsigned PB_TMR2  = 5;
  localparam int unsigned PB_CHKST = 6;
  localparam int unsigned PB_ERRST = 7;
  localparam int unsigned RTC_NMI  = 7;

  typedef struct packed {
    logic chk_en;
    logic err_en;
    logic spk_en;
  } pb_ctrl_t;
endpackage

// File: rtl/err_src_qual.sv
module err_src_qual (
  input  logic perr_pulse,
  input  logic serr_pulse,
  input  logic cfg_perr_en,
  input  logic cfg_serr_en,
  input  logic cfg_perr_to_serr,
  output logic err_hit
);
  logic perr_q, serr_q;
  always_comb begin
    perr_q  = perr_pulse & cfg_perr_en & cfg_perr_to_serr;
    serr_q  = serr_pulse & cfg_serr_en;
    err_hit = perr_q | serr_q;
  end
endmodule

// File: rtl/sysctl_portb.sv
module sysctl_portb
  import err_nmi_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  pb_ctrl_t   wr_ctrl,
  input  logic       err_hit,
  input  logic       chk_hit,
  input  logic       tmr1,
  input  logic       tmr2,
  output pb_ctrl_t   ctrl,
  output logic       err_sts,
  output logic       chk_sts,
  output logic [7:0] rd_val
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl    <= '0;
      err_sts <= 1'b0;
      chk_sts <= 1'b0;
    end else begin
      if (wr_en) ctrl <= wr_ctrl;
      if (wr_en && !wr_ctrl.err_en)        err_sts <= 1'b0;
      else if (ctrl.err_en && err_hit)     err_sts <= 1'b1;
      if (wr_en && !wr_ctrl.chk_en)        chk_sts <= 1'b0;
      else if (ctrl.chk_en && chk_hit)     chk_sts <= 1'b1;
    end
  end

  always_comb begin
    rd_val           = '0;
    rd_val[PB_SPK]   = ctrl.spk_en;
    rd_val[PB_ERREN] = ctrl.err_en;
    rd_val[PB_CHKEN] = ctrl.chk_en;
    rd_val[PB_TMR1]  = tmr1;
    rd_val[PB_TMR2]  = tmr2;
    rd_val[PB_CHKST] = chk_sts;
    rd_val[PB_ERRST] = err_sts;
  end

  p_err_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_ctrl.err_en) |=> !err_sts);
  p_chk_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_ctrl.chk_en) |=> !chk_sts);
  p_err_latch_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.err_en && err_hit && !wr_en) |=> err_sts);
  p_chk_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl.chk_en && !wr_en) |=> !chk_sts);
endmodule

// File: rtl/rtc_nmi_idx.sv
module rtc_nmi_idx
  import err_nmi_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wdata,
  output logic       nmi_en,
  output logic [7:0] rd_val
);
  logic [6:0] idx;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nmi_en <= 1'b0;
      idx    <= '0;
    end else if (wr_en) begin
      nmi_en <= wdata[RTC_NMI];
      idx    <= wdata[6:0];
    end
  end
  assign rd_val = {1'b0, idx};
endmodule

// File: rtl/nmi_smi_edge.sv
module nmi_smi_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic nmi_en,
  input  logic err_sts,
  input  logic chk_sts,
  output logic smi_req
);
  logic cond, cond_q;
  assign cond = nmi_en & (err_sts | chk_sts);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cond_q  <= 1'b0;
      smi_req <= 1'b0;
    end else begin
      cond_q  <= cond;
      smi_req <= cond & ~cond_q;
    end
  end

  p_single_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    smi_req |=> !smi_req);
  p_rise_fires_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cond) |=> smi_req);
  p_masked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    smi_req |-> $past(nmi_en));
endmodule

// File: rtl/err_nmi_smi.sv
module err_nmi_smi
  import err_nmi_pkg::*;
#(
  parameter int unsigned ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] PORTB_ADDR = 'h61,
  parameter logic [ADDR_W-1:0] RTC_ADDR   = 'h70
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic [7:0]        io_wdata,
  output logic [7:0]        io_rdata,
  input  logic              cfg_perr_en,
  input  logic              cfg_serr_en,
  input  logic              cfg_perr_to_serr,
  input  logic              perr_pulse,
  input  logic              serr_pulse,
  input  logic              iochk_pulse,
  input  logic              tmr1_out,
  input  logic              tmr2_out,
  output logic              spk_out,
  output logic              smi_req
);
  logic hit_pb, hit_rtc, err_hit, err_sts, chk_sts, nmi_en;
  logic [7:0] pb_rd, rtc_rd;
  pb_ctrl_t ctrl, wr_ctrl;

  assign hit_pb  = (io_addr == PORTB_ADDR);
  assign hit_rtc = (io_addr == RTC_ADDR);
  assign wr_ctrl = '{chk_en: io_wdata[PB_CHKEN], err_en: io_wdata[PB_ERREN],
                     spk_en: io_wdata[PB_SPK]};

  err_src_qual u_qual (
    .perr_pulse(perr_pulse), .serr_pulse(serr_pulse),
    .cfg_perr_en(cfg_perr_en), .cfg_serr_en(cfg_serr_en),
    .cfg_perr_to_serr(cfg_perr_to_serr), .err_hit(err_hit));

  sysctl_portb u_pb (
    .clk(clk), .rst_n(rst_n), .wr_en(io_wr && hit_pb), .wr_ctrl(wr_ctrl),
    .err_hit(err_hit), .chk_hit(iochk_pulse), .tmr1(tmr1_out), .tmr2(tmr2_out),
    .ctrl(ctrl), .err_sts(err_sts), .chk_sts(chk_sts), .rd_val(pb_rd));

  rtc_nmi_idx u_rtc (
    .clk(clk), .rst_n(rst_n), .wr_en(io_wr && hit_rtc), .wdata(io_wdata),
    .nmi_en(nmi_en), .rd_val(rtc_rd));

  nmi_smi_edge u_edge (
    .clk(clk), .rst_n(rst_n), .nmi_en(nmi_en), .err_sts(err_sts),
    .chk_sts(chk_sts), .smi_req(smi_req));

  assign spk_out = tmr2_out & ctrl.spk_en;

  always_comb begin
    io_rdata = '0;
    if (io_rd && hit_pb)       io_rdata = pb_rd;
    else if (io_rd && hit_rtc) io_rdata = rtc_rd;
  end

  p_rtc_hidden_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && hit_rtc) |-> !io_rdata[7]);
  p_idle_bus_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !io_rd |-> (io_rdata == 8'h00));
  p_spk_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !tmr2_out |-> !spk_out);
endmodule

// File: tb/sim_err_nmi_smi.sv
module sim_err_nmi_smi;
  logic clk = 0, rst_n = 0, io_wr = 0, io_rd = 0;
  logic [15:0] io_addr = 0;
  logic [7:0] io_wdata = 0, io_rdata;
  logic cfg_perr_en = 0, cfg_serr_en = 0, cfg_perr_to_serr = 0;
  logic perr_pulse = 0, serr_pulse = 0, iochk_pulse = 0;
  logic tmr1_out = 0, tmr2_out = 0, spk_out, smi_req;
  int checks = 0, errors = 0, smi_cnt = 0;
  bit done = 0;

  always #5 clk = ~clk;

  err_nmi_smi u0 (.*);

  always @(negedge clk) if (rst_n && smi_req) smi_cnt++;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [15:0] a, logic [7:0] d);
    @(negedge clk); io_wr = 1; io_addr = a; io_wdata = d;
    @(negedge clk); io_wr = 0;
  endtask

  task automatic rd(logic [15:0] a, output logic [7:0] d);
    @(negedge clk); io_rd = 1; io_addr = a; #1 d = io_rdata;
    @(negedge clk); io_rd = 0;
  endtask

  task automatic strobe(int which);
    @(negedge clk);
    if (which == 0) perr_pulse = 1; else if (which == 1) serr_pulse = 1; else iochk_pulse = 1;
    @(negedge clk); perr_pulse = 0; serr_pulse = 0; iochk_pulse = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    tmr1_out = 1; tmr2_out = 0;
    rd(16'h61, d);
    chk("R1 R3 reset readback", d, 8'h10);
    chk("R1 smi", smi_req, 0);
    tmr2_out = 1; #1;
    chk("R1 spk", spk_out, 0);
    rd(16'h70, d);
    chk("R1 rtc", d, 8'h00);
  endtask

  task automatic t_speaker();
    logic [7:0] d;
    wr(16'h61, 8'h02);
    tmr2_out = 1; #1 chk("R2 spk high", spk_out, 1);
    tmr2_out = 0; #1 chk("R2 spk low", spk_out, 0);
    tmr1_out = 0; tmr2_out = 1;
    rd(16'h61, d);
    chk("R3 readback spk", d, 8'h22);
    tmr2_out = 0;
    wr(16'h61, 8'h00);
  endtask

  task automatic t_parity();
    logic [7:0] d; int c0;
    wr(16'h70, 8'h80); wr(16'h61, 8'h04);
    cfg_perr_en = 1; cfg_perr_to_serr = 0; c0 = smi_cnt;
    strobe(0); idle(3); rd(16'h61, d);
    chk("R4 perr without to_serr", d[7], 0);
    cfg_perr_en = 0; cfg_perr_to_serr = 1;
    strobe(0); idle(3); rd(16'h61, d);
    chk("R4 perr without perr_en", d[7], 0);
    chk("R4 no smi", smi_cnt - c0, 0);
    cfg_perr_en = 1;
    strobe(0);
    chk("R7 not yet", smi_req, 0);
    @(negedge clk);
    chk("R7 pulse timing", smi_req, 1);
    @(negedge clk);
    chk("R7 one cycle", smi_req, 0);
    rd(16'h61, d);
    chk("R4 status set", d, 8'h84);
    c0 = smi_cnt;
    strobe(0); strobe(2); idle(4);
    chk("R8 no refire", smi_cnt - c0, 0);
    wr(16'h61, 8'h00); rd(16'h61, d);
    chk("R6 cleared", d[7], 0);
    wr(16'h61, 8'h04); rd(16'h61, d);
    chk("R6 stays clear", d[7], 0);
    cfg_perr_en = 0; cfg_perr_to_serr = 0;
  endtask

  task automatic t_serr();
    logic [7:0] d; int c0;
    c0 = smi_cnt;
    cfg_serr_en = 0; strobe(1); idle(3); rd(16'h61, d);
    chk("R5 serr masked", d[7], 0);
    cfg_serr_en = 1; strobe(1); idle(3); rd(16'h61, d);
    chk("R5 serr set", d[7], 1);
    chk("R5 one smi", smi_cnt - c0, 1);
    wr(16'h61, 8'h00); cfg_serr_en = 0;
  endtask

  task automatic t_iochk();
    logic [7:0] d; int c0;
    c0 = smi_cnt;
    strobe(2); idle(3); rd(16'h61, d);
    chk("R6 chk disabled", d[6], 0);
    wr(16'h61, 8'h08); strobe(2); idle(3); rd(16'h61, d);
    chk("R6 chk latched", d, 8'h48);
    chk("R6 chk smi", smi_cnt - c0, 1);
    wr(16'h61, 8'h00); rd(16'h61, d);
    chk("R6 chk cleared", d[6], 0);
  endtask

  task automatic t_mask();
    logic [7:0] d; int c0;
    wr(16'h70, 8'h05); c0 = smi_cnt;
    wr(16'h61, 8'h08); strobe(2); idle(4);
    chk("R9 masked", smi_cnt - c0, 0);
    rd(16'h70, d);
    chk("R10 rtc read", d, 8'h05);
    wr(16'h70, 8'h85); idle(3);
    chk("R9 enable fires", smi_cnt - c0, 1);
    rd(16'h70, d);
    chk("R10 bit7 hidden", d, 8'h05);
    rd(16'h62, d);
    chk("R11 other addr", d, 8'h00);
    #1 chk("R11 no read", io_rdata, 8'h00);
    wr(16'h61, 8'h00);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk); rst_n = 1;
        t_reset(); t_speaker(); t_parity(); t_serr(); t_iochk(); t_mask();
        done = 1;
      end
      begin
        repeat (20000) @(negedge clk);
        if (!done) begin
          checks++; errors++;
          $display("FAIL watchdog actual=hung expected=done");
        end
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule